// File: doc/BRIEF.md
# SMBus Bus Timeout Detector

This block watches the already-synchronized clock and data lines of an SMBus segment and counts bus clock cycles in three independent monitors. One monitor catches a clock line held low for too long. A second monitor reports that both lines have stayed high for the short high period, which means the bus is idle. A third monitor uses the same short period and catches the clock line held high while the data line stays low.

The clock-low flag and the clock-high/data-low flag are sticky. Software clears each one by writing a 1 to its bit in the status location. The idle flag is only a status level. It drops by itself as soon as either line leaves the high state, and it never reaches the interrupt output. A global interrupt enable gates the single interrupt output. The clock-high/data-low flag also has its own separate enable. Software sets the two periods and the control bits through a simple write-only port.

Top module: `smbus_tmo_det`

## Requirements
- R1: With a nonzero low period P in address 0, `flag_low_o` rises after the P-th consecutive rising clock edge that samples `scl_i`=0, and not earlier.
- R2: `flag_low_o` stays set until software writes a value with bit 0 set to address 3. A write to address 3 with bit 0 clear leaves it set.
- R3: With a nonzero high period H in address 1, `flag_idle_o` rises after H consecutive edges that sample `scl_i`=1 and `sda_i`=1. It falls after the first edge at which that condition no longer holds, without any software action.
- R4: `flag_idle_o` has no effect on `irq_o`, whatever the enables are.
- R5: `flag_high2_o` rises after H consecutive edges that sample `scl_i`=1 and `sda_i`=0. It stays set until a write to address 3 with bit 1 set.
- R6: Any edge at which a monitor's line condition does not hold restarts that monitor's count from zero.
- R7: Once a monitor has fired, it does not fire again until its condition breaks, even if its flag has been cleared while the condition is still held.
- R8: A period value of zero disables that monitor, and its flag never rises.
- R9: `irq_o` equals GIE AND (`flag_low_o` OR (H2IE AND `flag_high2_o`)). Here GIE is bit 0 and H2IE is bit 1 of address 2.
- R10: After a synchronous reset all flags, `irq_o`, both periods and both enables are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized clock line level |
| sda_i | input | 1 | Synchronized data line level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 low period, 1 high period, 2 control, 3 status clear |
| wr_data | input | CNT_W | Write data |
| flag_low_o | output | 1 | Sticky clock-low timeout flag |
| flag_idle_o | output | 1 | Self-clearing bus-idle flag |
| flag_high2_o | output | 1 | Sticky clock-high/data-low timeout flag |
| irq_o | output | 1 | Timeout interrupt |

## Verification
The bench builds the block with CNT_W set to 8. This lets a full-scale period of 255 run within the time budget and places the saturation point at the counter's widest value. The short periods of 5 and 20 cycles allow the bench to hit the exact firing edge, a restart one cycle before it, and a clear while the condition is still held, all to the cycle. Writing zero to each period then shows that each monitor turns off separately.

// File: rtl/smbus_tmo_pkg.sv
package smbus_tmo_pkg;

    typedef enum logic [1:0] {
        ADDR_PER_LOW  = 2'd0,
        ADDR_PER_HIGH = 2'd1,
        ADDR_CTRL     = 2'd2,
        ADDR_STATUS   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic high2_ie;
        logic glob_ie;
    } ctrl_t;

    localparam int N_MON    = 3;
    localparam int MON_LOW  = 0;
    localparam int MON_IDLE = 1;
    localparam int MON_HOLD = 2;

    function automatic logic mon_cond(input int kind, input logic scl, input logic sda);
        logic c;
        case (kind)
            MON_LOW:  c = !scl;
            MON_IDLE: c = scl && sda;
            default:  c = scl && !sda;
        endcase
        return c;
    endfunction

    function automatic logic uses_low_period(input int kind);
        return kind == MON_LOW;
    endfunction

endpackage

// File: rtl/smbus_tmo_regs.sv
module smbus_tmo_regs
    import smbus_tmo_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] per_low,
    output logic [CNT_W-1:0] per_high,
    output ctrl_t            ctrl,
    output logic             clr_low,
    output logic             clr_hold
);
    reg_addr_e addr;
    assign addr = reg_addr_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            per_low  <= '0;
            per_high <= '0;
            ctrl     <= '0;
        end else if (wr_en) begin
            case (addr)
                ADDR_PER_LOW:  per_low  <= wr_data;
                ADDR_PER_HIGH: per_high <= wr_data;
                ADDR_CTRL:     ctrl     <= ctrl_t'(wr_data[1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        clr_low  = wr_en && (addr == ADDR_STATUS) && wr_data[0];
        clr_hold = wr_en && (addr == ADDR_STATUS) && wr_data[1];
    end

    p_reset_clears_r10: assert property (@(posedge clk)
        rst |=> (per_low == '0 && per_high == '0 && ctrl == '0));

endmodule

// File: rtl/smbus_tmo_counter.sv
module smbus_tmo_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cond,
    input  logic [CNT_W-1:0] period,
    output logic             hit_o
);
    logic [CNT_W-1:0] cnt;
    logic             enabled;

    assign enabled = (period != '0);
    assign hit_o   = enabled && cond && (cnt == period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !cond || !enabled) begin
            cnt <= '0;
        end else if (cnt != period) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        !cond |=> (cnt == '0));

    p_no_rehit_r7: assert property (@(posedge clk) disable iff (rst)
        (hit_o && $stable(period)) ##1 $stable(period) |-> !hit_o);

    p_zero_off_r8: assert property (@(posedge clk) disable iff (rst)
        (period == '0) |=> (cnt == '0));

endmodule

// File: rtl/smbus_tmo_flags.sv
module smbus_tmo_flags
    import smbus_tmo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_MON-1:0] hit,
    input  logic             idle_cond,
    input  logic             clr_low,
    input  logic             clr_hold,
    input  ctrl_t            ctrl,
    output logic             flag_low,
    output logic             flag_idle,
    output logic             flag_hold,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_low  <= 1'b0;
            flag_idle <= 1'b0;
            flag_hold <= 1'b0;
        end else begin
            flag_low  <= hit[MON_LOW]  || (flag_low  && !clr_low);
            flag_hold <= hit[MON_HOLD] || (flag_hold && !clr_hold);
            flag_idle <= idle_cond && (hit[MON_IDLE] || flag_idle);
        end
    end

    assign irq = ctrl.glob_ie && (flag_low || (ctrl.high2_ie && flag_hold));

    p_idle_selfclear_r3: assert property (@(posedge clk) disable iff (rst)
        !idle_cond |=> !flag_idle);

    p_irq_source_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag_low || flag_hold));

    p_low_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        (flag_low && !clr_low) |=> flag_low);

    p_hold_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_hold && !clr_hold) |=> flag_hold);

    p_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !ctrl.glob_ie |-> !irq);

endmodule

// File: rtl/smbus_tmo_det.sv
module smbus_tmo_det
    import smbus_tmo_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             flag_low_o,
    output logic             flag_idle_o,
    output logic             flag_high2_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] per_low;
    logic [CNT_W-1:0] per_high;
    ctrl_t            ctrl;
    logic             clr_low;
    logic             clr_hold;
    logic [N_MON-1:0] hit;
    logic [N_MON-1:0] cond;

    smbus_tmo_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .per_low  (per_low),
        .per_high (per_high),
        .ctrl     (ctrl),
        .clr_low  (clr_low),
        .clr_hold (clr_hold)
    );

    for (genvar i = 0; i < N_MON; i++) begin : g_mon
        assign cond[i] = mon_cond(i, scl_i, sda_i);
        smbus_tmo_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst    (rst),
            .cond   (cond[i]),
            .period (uses_low_period(i) ? per_low : per_high),
            .hit_o  (hit[i])
        );
    end

    smbus_tmo_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .idle_cond (cond[MON_IDLE]),
        .clr_low   (clr_low),
        .clr_hold  (clr_hold),
        .ctrl      (ctrl),
        .flag_low  (flag_low_o),
        .flag_idle (flag_idle_o),
        .flag_hold (flag_high2_o),
        .irq       (irq_o)
    );

    p_low_from_scl_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_low_o) |-> $past(!scl_i));

endmodule

// File: tb/smbus_tmo_det_bench.sv
module smbus_tmo_det_bench;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             scl = 1'b1;
    logic             sda = 1'b1;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = 2'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic             f_low, f_idle, f_hold, irq;
    int               checks = 0;
    int               errors = 0;

    always #5 clk = ~clk;

    smbus_tmo_det #(.CNT_W(CNT_W)) u_smbus_tmo_det (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .flag_low_o(f_low), .flag_idle_o(f_idle),
        .flag_high2_o(f_hold), .irq_o(irq)
    );

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lines(input logic c, input logic d, input int n);
        scl = c; sda = d;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        check(f_low, 1'b0, "R10 low flag after reset");
        check(f_idle, 1'b0, "R10 idle flag after reset");
        check(f_hold, 1'b0, "R10 high2 flag after reset");
        check(irq, 1'b0, "R10 irq after reset");
        lines(1'b0, 1'b1, 40);
        check(f_low, 1'b0, "R10 zero low period after reset");
        lines(1'b1, 1'b0, 40);
        check(f_hold, 1'b0, "R10 zero high period after reset");
    endtask

    task automatic t_low();
        lines(1'b1, 1'b1, 2);
        wr(2'd0, 8'd20);
        wr(2'd1, 8'd5);
        lines(1'b0, 1'b1, 19);
        check(f_low, 1'b0, "R1 low flag one edge early");
        lines(1'b0, 1'b1, 1);
        check(f_low, 1'b1, "R1 low flag at period");
        lines(1'b1, 1'b1, 3);
        check(f_low, 1'b1, "R2 low flag sticky");
        check(irq, 1'b0, "R9 irq without global enable");
        wr(2'd3, 8'h00);
        check(f_low, 1'b1, "R2 write zero leaves flag");
        wr(2'd3, 8'h01);
        check(f_low, 1'b0, "R2 write one clears flag");
    endtask

    task automatic t_idle();
        lines(1'b0, 1'b1, 1);
        wr(2'd2, 8'h03);
        lines(1'b1, 1'b1, 4);
        check(f_idle, 1'b0, "R3 idle flag one edge early");
        lines(1'b1, 1'b1, 1);
        check(f_idle, 1'b1, "R3 idle flag at period");
        check(irq, 1'b0, "R4 idle flag gives no irq");
        lines(1'b1, 1'b1, 10);
        check(f_idle, 1'b1, "R3 idle flag holds");
        check(irq, 1'b0, "R4 idle flag held gives no irq");
        lines(1'b1, 1'b0, 1);
        check(f_idle, 1'b0, "R3 idle flag falls by itself");
    endtask

    task automatic t_hold();
        lines(1'b0, 1'b0, 1);
        wr(2'd2, 8'h01);
        lines(1'b1, 1'b0, 4);
        check(f_hold, 1'b0, "R5 high2 flag one edge early");
        lines(1'b1, 1'b0, 1);
        check(f_hold, 1'b1, "R5 high2 flag at period");
        check(irq, 1'b0, "R9 high2 without its enable");
        wr(2'd2, 8'h03);
        check(irq, 1'b1, "R9 high2 with both enables");
        wr(2'd3, 8'h02);
        check(f_hold, 1'b0, "R5 high2 write one clears");
        check(irq, 1'b0, "R9 irq drops after clear");
        lines(1'b1, 1'b0, 10);
        check(f_hold, 1'b0, "R7 no refire while held");
    endtask

    task automatic t_restart();
        lines(1'b0, 1'b0, 1);
        lines(1'b1, 1'b0, 4);
        lines(1'b1, 1'b1, 1);
        lines(1'b1, 1'b0, 4);
        check(f_hold, 1'b0, "R6 count restarted after break");
        lines(1'b1, 1'b0, 1);
        check(f_hold, 1'b1, "R6 fires after full run");
        wr(2'd3, 8'h02);
        check(f_hold, 1'b0, "R5 cleared again");
    endtask

    task automatic t_irq_low();
        wr(2'd2, 8'h01);
        lines(1'b0, 1'b1, 20);
        check(f_low, 1'b1, "R1 low flag second run");
        check(irq, 1'b1, "R9 irq from low flag");
        wr(2'd2, 8'h00);
        check(irq, 1'b0, "R9 irq gated by global enable");
        check(f_low, 1'b1, "R2 flag kept while gated");
        wr(2'd3, 8'h01);
        check(f_low, 1'b0, "R2 cleared");
    endtask

    task automatic t_zero();
        wr(2'd1, 8'd0);
        lines(1'b1, 1'b1, 40);
        check(f_idle, 1'b0, "R8 zero high period idle");
        lines(1'b1, 1'b0, 40);
        check(f_hold, 1'b0, "R8 zero high period high2");
        wr(2'd0, 8'd0);
        lines(1'b0, 1'b1, 40);
        check(f_low, 1'b0, "R8 zero low period");
    endtask

    task automatic t_full();
        lines(1'b1, 1'b1, 1);
        wr(2'd0, 8'd255);
        lines(1'b0, 1'b1, 254);
        check(f_low, 1'b0, "R1 full-scale one edge early");
        lines(1'b0, 1'b1, 1);
        check(f_low, 1'b1, "R1 full-scale period");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_low();
        t_idle();
        t_hold();
        t_restart();
        t_irq_low();
        t_zero();
        t_full();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule